// File: doc/BRIEF.md
# Stereo serial audio bus master with programmable frame length

This block is the bus-master end of a stereo I2S link. It divides the master clock down to a bit clock, drives the word-select line, shifts a stereo playback stream out on the data-out pin and captures a stereo record stream from the data-in pin. The number of bit clocks in one sample frame can be set at run time to any even value from 8 to 254. It does not have to be a power of two, so frames of 50, 96, 100, 120, 200 or 254 bit clocks all work. Each channel slot takes half the frame.

Samples are exchanged as 32-bit left-justified words. Playback words enter through a valid/ready handshake into a one-word buffer. Record words leave with a valid/ready handshake and a channel flag. A slot longer than 32 bits sends zeros after the word, and the extra captured bits are dropped. A slot shorter than 32 bits moves only its top bits, so capture stays locked to the word-select edge.

The master clock is the block clock. Configuration is taken while the bus is idle and again at every frame start. After the enable input drops, the current frame finishes and the bus goes idle.

Top module: `i2s_frame_master`

## Requirements
- R1: After reset the bus is idle: `bclk` high, `lrck` low, `sdout` low, `dac_ready` high, `adc_valid` and `dac_underrun` low.
- R2: While running, one `bclk` period lasts 2*(`cfg_div`+1) clock cycles. `lrck` and `sdout` change only on a falling `bclk` edge, and `sdin` is sampled on a rising edge.
- R3: A frame lasts `cfg_frame_len` bit clocks. The left slot and the right slot each last half of that, and slots alternate left, right.
- R4: `lrck` rises one bit clock before the left slot ends and falls one bit clock before the right slot ends. The bit after each `lrck` change is the MSB of the next slot, so `lrck` is low during the left slot and high during the right slot apart from that last bit.
- R5: Data goes out MSB first, starting at word bit 31. In a slot longer than 32 bits, every bit after the 32nd is 0.
- R6: In a slot of H < 32 bits, word bits 31 down to 32-H are sent. The captured word holds those bits, and its lower bits are 0.
- R7: The bits sampled during a slot are presented on `adc_data` at the end of that slot, with `adc_right` = 1 for the right slot. `adc_valid` stays high until `adc_ready` accepts the word. With `sdout` looped to `sdin`, the word 0x12345678 comes back unchanged.
- R8: A playback word is accepted on a cycle with `dac_valid` and `dac_ready` both high. After that, `dac_ready` stays low until the word has been taken at the next slot start. Words fill slots in the order left, right, left, and so on.
- R9: If no word is buffered when a slot starts, that slot sends all zeros and `dac_underrun` pulses high for one cycle.
- R10: `cfg_frame_len` and `cfg_div` are taken only while idle or at a frame start. A change made in the middle of a frame first applies to the next left slot.
- R11: When `en` is high on an idle bus, the first falling `bclk` edge starts a left slot. When `en` goes low, the current frame completes and the bus then returns to the idle levels of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, also the block clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run request; sampled while idle and at frame end |
| cfg_frame_len | input | 8 | Bit clocks per frame, even, 8 to 254 |
| cfg_div | input | DIVW | Half bit-clock period minus one, in clock cycles |
| dac_data | input | DW | Playback word, left-justified |
| dac_valid | input | 1 | Playback word offered |
| dac_ready | output | 1 | Playback buffer empty |
| dac_underrun | output | 1 | One-cycle pulse: slot started with no word |
| adc_data | output | DW | Captured word, left-justified |
| adc_right | output | 1 | Captured word belongs to the right slot |
| adc_valid | output | 1 | Captured word available |
| adc_ready | input | 1 | Consumer takes the captured word |
| bclk | output | 1 | Bit clock |
| lrck | output | 1 | Word select, low for left |
| sdout | output | 1 | Serial playback data |
| sdin | input | 1 | Serial record data |

## Verification
The hardest case to reach is a frame-length change that lands in the middle of a frame. It has to leave the running right slot at its old length, and the next left slot has to open at the new length. The bench triggers the change from its own bus monitor, as soon as it sees the first right-slot bit, and then checks the length of every decoded slot. Capture alignment is checked with `sdout` looped to `sdin` at odd slot lengths (25, 48, 50, 60, 100). A 4-bit misalignment would appear as a shifted word such as 0x23456780.

// File: rtl/i2s_frame_pkg.sv
package i2s_frame_pkg;

  // Frame position width: frames up to 254 bit clocks.
  localparam int FLW = 8;

  // Where a frame position lies: which channel, bit index in the slot,
  // word-select level and whether it opens a slot.
  typedef struct packed {
    logic           lrck;
    logic           right;
    logic [FLW-1:0] k;
    logic           start;
  } slot_map_t;

  function automatic slot_map_t map_pos(input logic [FLW-1:0] pos,
                                        input logic [FLW-1:0] flen);
    logic [FLW-1:0] half;
    slot_map_t      m;
    half    = flen >> 1;
    m.right = (pos >= half);
    m.k     = m.right ? (pos - half) : pos;
    // Word select flips one bit before the slot it announces.
    m.lrck  = (pos >= (half - 1'b1)) && (pos != (flen - 1'b1));
    m.start = (m.k == '0);
    return m;
  endfunction

endpackage

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            bclk,
  output logic            fall_evt,
  output logic            rise_evt
);

  logic [DIVW-1:0] cnt_q;
  logic            bclk_q;
  logic            tick;

  assign tick     = run && (cnt_q == div);
  assign fall_evt = tick && bclk_q;
  assign rise_evt = tick && !bclk_q;
  assign bclk     = bclk_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      bclk_q <= 1'b1;
    end else if (tick) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/i2s_tx_lane.sv
module i2s_tx_lane #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          fall_evt,
  input  logic          slot_start,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          sdo,
  output logic          underrun
);

  logic [DW-1:0] buf_q;
  logic [DW-1:0] sh_q;
  logic          full_q;
  logic          sdo_q;
  logic          unr_q;

  assign in_ready = !full_q;
  assign sdo      = sdo_q;
  assign underrun = unr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q  <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
      sdo_q  <= 1'b0;
      unr_q  <= 1'b0;
    end else begin
      unr_q <= 1'b0;
      if (fall_evt && slot_start) begin
        if (full_q) begin
          sdo_q  <= buf_q[DW-1];
          sh_q   <= buf_q << 1;
          full_q <= 1'b0;
        end else begin
          sdo_q <= 1'b0;
          sh_q  <= '0;
          unr_q <= 1'b1;
        end
      end else if (fall_evt) begin
        // Zeros shift in behind the word: long slots pad by themselves.
        sdo_q <= sh_q[DW-1];
        sh_q  <= sh_q << 1;
      end else if (!run) begin
        sdo_q <= 1'b0;
      end
      // Accept only into an empty buffer; never coincides with a load.
      if (in_valid && !full_q) begin
        buf_q  <= in_data;
        full_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2s_rx_lane.sv
module i2s_rx_lane #(
  parameter int DW  = 32,
  parameter int FLW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rise_evt,
  input  logic [FLW-1:0] k,
  input  logic           last,
  input  logic           right,
  input  logic           sdi,
  output logic [DW-1:0]  out_data,
  output logic           out_right,
  output logic           out_valid,
  input  logic           out_ready
);

  localparam int IW = $clog2(DW);

  logic [DW-1:0] cap_q;
  logic [DW-1:0] cap_n;
  logic [DW-1:0] data_q;
  logic          right_q;
  logic          valid_q;

  always_comb begin
    cap_n = (k == '0) ? '0 : cap_q;
    if (k < FLW'(DW)) begin
      cap_n[IW'(DW-1) - k[IW-1:0]] = sdi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= '0;
      data_q  <= '0;
      right_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (valid_q && out_ready) begin
        valid_q <= 1'b0;
      end
      if (rise_evt) begin
        cap_q <= cap_n;
        if (last) begin
          data_q  <= cap_n;
          right_q <= right;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign out_data  = data_q;
  assign out_right = right_q;
  assign out_valid = valid_q;

endmodule

// File: rtl/i2s_frame_master.sv
module i2s_frame_master #(
  parameter int DW   = 32,
  parameter int DIVW = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic [i2s_frame_pkg::FLW-1:0] cfg_frame_len,
  input  logic [DIVW-1:0]            cfg_div,
  input  logic [DW-1:0]              dac_data,
  input  logic                       dac_valid,
  output logic                       dac_ready,
  output logic                       dac_underrun,
  output logic [DW-1:0]              adc_data,
  output logic                       adc_right,
  output logic                       adc_valid,
  input  logic                       adc_ready,
  output logic                       bclk,
  output logic                       lrck,
  output logic                       sdout,
  input  logic                       sdin
);

  import i2s_frame_pkg::*;

  logic           run_q;
  logic [FLW-1:0] pos_q;
  logic [FLW-1:0] flen_q;
  logic [DIVW-1:0] div_q;
  logic           lrck_q;
  logic           right_q;
  logic [FLW-1:0] k_q;

  logic           fall_evt;
  logic           rise_evt;
  logic           wrap;
  logic [FLW-1:0] flen_n;
  logic [FLW-1:0] pos_n;
  logic [FLW-1:0] half_q;
  logic           last_bit;
  slot_map_t      map_n;

  // Next bit position; frame length is re-read only when a frame wraps.
  assign wrap     = (pos_q == (flen_q - 1'b1));
  assign flen_n   = wrap ? cfg_frame_len : flen_q;
  assign pos_n    = wrap ? '0 : (pos_q + 1'b1);
  assign map_n    = map_pos(pos_n, flen_n);
  assign half_q   = flen_q >> 1;
  assign last_bit = (k_q == (half_q - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      pos_q   <= '0;
      flen_q  <= '0;
      div_q   <= '0;
      lrck_q  <= 1'b0;
      right_q <= 1'b1;
      k_q     <= '0;
    end else if (!run_q) begin
      // Idle: everything set up before the bit clock starts.
      flen_q  <= cfg_frame_len;
      div_q   <= cfg_div;
      pos_q   <= cfg_frame_len - 1'b1;
      lrck_q  <= 1'b0;
      right_q <= 1'b1;
      k_q     <= (cfg_frame_len >> 1) - 1'b1;
      run_q   <= en;
    end else begin
      if (fall_evt) begin
        pos_q   <= pos_n;
        flen_q  <= flen_n;
        lrck_q  <= map_n.lrck;
        right_q <= map_n.right;
        k_q     <= map_n.k;
        if (wrap) begin
          div_q <= cfg_div;
        end
      end
      if (rise_evt && wrap && !en) begin
        run_q <= 1'b0;
      end
    end
  end

  assign lrck = lrck_q;

  i2s_bclk_gen #(.DIVW(DIVW)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .div      (div_q),
    .bclk     (bclk),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt)
  );

  i2s_tx_lane #(.DW(DW)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .run        (run_q),
    .fall_evt   (fall_evt),
    .slot_start (map_n.start),
    .in_data    (dac_data),
    .in_valid   (dac_valid),
    .in_ready   (dac_ready),
    .sdo        (sdout),
    .underrun   (dac_underrun)
  );

  i2s_rx_lane #(.DW(DW), .FLW(FLW)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .rise_evt  (rise_evt),
    .k         (k_q),
    .last      (last_bit),
    .right     (right_q),
    .sdi       (sdin),
    .out_data  (adc_data),
    .out_right (adc_right),
    .out_valid (adc_valid),
    .out_ready (adc_ready)
  );

endmodule

// File: rtl/i2s_frame_master_chk.sv
module i2s_frame_master_chk (
  input logic clk,
  input logic rst,
  input logic run,
  input logic bclk,
  input logic lrck,
  input logic sdout,
  input logic dac_valid,
  input logic dac_ready,
  input logic dac_underrun,
  input logic adc_valid,
  input logic adc_ready
);

  // R2: word select moves only with a falling bit clock
  p_lrck_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrck) |-> $fell(bclk));

  // R2: data out moves only with a falling bit clock while running
  p_sdout_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sdout) && $past(run)) |-> $fell(bclk));

  // R11: idle bus holds bit clock high and word select low
  p_idle_levels_r11: assert property (@(posedge clk) disable iff (rst)
    !run |-> (bclk && !lrck));

  // R9: underrun is a single-cycle pulse
  p_underrun_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    dac_underrun |=> !dac_underrun);

  // R8: an accepted word fills the buffer
  p_buffer_fills_r8: assert property (@(posedge clk) disable iff (rst)
    (dac_valid && dac_ready) |=> !dac_ready);

  // R7: captured word held until taken
  p_adc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (adc_valid && !adc_ready) |=> adc_valid);

endmodule

bind i2s_frame_master i2s_frame_master_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .run          (run_q),
  .bclk         (bclk),
  .lrck         (lrck),
  .sdout        (sdout),
  .dac_valid    (dac_valid),
  .dac_ready    (dac_ready),
  .dac_underrun (dac_underrun),
  .adc_valid    (adc_valid),
  .adc_ready    (adc_ready)
);

// File: tb/sim_i2s_frame_master.sv
module sim_i2s_frame_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [7:0]  cfg_len = 8'd100;
  logic [7:0]  cfg_div = 8'd0;
  logic [31:0] dac_data = '0;
  logic        dac_valid = 1'b0;
  logic        dac_ready, dac_underrun;
  logic [31:0] adc_data;
  logic        adc_right, adc_valid;
  logic        adc_ready = 1'b1;
  logic        bclk, lrck, sdout, sdin;

  assign sdin = sdout;  // loopback

  always #4 clk = ~clk;

  i2s_frame_master u0 (
    .clk(clk), .rst(rst), .en(en), .cfg_frame_len(cfg_len), .cfg_div(cfg_div),
    .dac_data(dac_data), .dac_valid(dac_valid), .dac_ready(dac_ready),
    .dac_underrun(dac_underrun), .adc_data(adc_data), .adc_right(adc_right),
    .adc_valid(adc_valid), .adc_ready(adc_ready), .bclk(bclk), .lrck(lrck),
    .sdout(sdout), .sdin(sdin)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Playback word source
  int          feed_idx = 0;
  int          feed_lim = 0;
  bit          feed_on = 0;
  bit          take = 0;
  logic [31:0] seed = 32'h0;

  function automatic logic [31:0] word_at(input int i);
    if (i == 0) return 32'h12345678;
    return (32'(i) * 32'h9E3779B9) ^ seed;
  endfunction

  function automatic logic [31:0] trunc(input logic [31:0] w, input int h);
    if (h >= 32) return w;
    return w & ~(32'hFFFF_FFFF >> h);
  endfunction

  always @(negedge clk) begin
    if (take) feed_idx++;
    if (feed_on && feed_idx < feed_lim) begin
      dac_valid = 1'b1;
      dac_data  = word_at(feed_idx);
    end else begin
      dac_valid = 1'b0;
    end
    take = dac_valid && dac_ready;
  end

  // Bus monitor: decodes slots from the pins alone
  bit          mon_clr = 0;
  int          mon_cnt, bi, per_cnt, last_per, unr_cnt, adc_cnt;
  logic [31:0] mon_w [0:63];
  int          mon_n [0:63];
  bit          mon_c [0:63];
  logic [31:0] adc_w [0:63];
  bit          adc_c [0:63];
  logic [31:0] cur_w;
  bit          cur_c, in_slot, next_start, next_chan, bclk_p, lr_p;

  always @(negedge clk) begin
    if (mon_clr) begin
      mon_cnt = 0; bi = 0; per_cnt = 0; last_per = 0; unr_cnt = 0; adc_cnt = 0;
      in_slot = 0; next_start = 1; next_chan = 0; bclk_p = 1; lr_p = 0;
      cur_w = '0; cur_c = 0;
    end else begin
      per_cnt++;
      if (dac_underrun) unr_cnt++;
      if (adc_valid && adc_ready) begin
        if (adc_cnt < 64) begin
          adc_w[adc_cnt] = adc_data;
          adc_c[adc_cnt] = adc_right;
        end
        adc_cnt++;
      end
      if (bclk && !bclk_p) begin
        last_per = per_cnt;
        per_cnt  = 0;
        if (next_start) begin
          if (in_slot) begin
            if (mon_cnt < 64) begin
              mon_w[mon_cnt] = cur_w;
              mon_n[mon_cnt] = bi;
              mon_c[mon_cnt] = cur_c;
            end
            mon_cnt++;
          end
          in_slot = 1; cur_c = next_chan; cur_w = '0; bi = 0; next_start = 0;
        end
        if (bi < 32) cur_w[31-bi] = sdout;
        bi++;
        if (lrck != lr_p) begin
          next_start = 1;
          next_chan  = lrck;
        end
        lr_p = lrck;
      end
      bclk_p = bclk;
    end
  end

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic restart(input logic [7:0] len, input logic [7:0] dv,
                         input logic [31:0] sd, input int lim);
    en = 0; feed_on = 0;
    rst = 1;
    clocks(3);
    cfg_len = len; cfg_div = dv; seed = sd;
    feed_idx = 0; feed_lim = lim; take = 0;
    mon_clr = 1;
    clocks(1);
    rst = 0; mon_clr = 0; feed_on = 1;
    clocks(4);
  endtask

  task automatic wait_slots(input int n, input int len, input int dv);
    int guard = 0;
    en = 1;
    while (mon_cnt < n && guard < 60000) begin
      clocks(1);
      guard++;
    end
    en = 0;
    clocks(2 * len * 2 * (dv + 1) + 20);
  endtask

  task automatic t_reset();
    restart(8'd100, 8'd0, 32'h0, 0);
    check(bclk == 1'b1, "R1", "bclk after reset", 32'(bclk), 32'd1);
    check(lrck == 1'b0, "R1", "lrck after reset", 32'(lrck), 32'd0);
    check(sdout == 1'b0, "R1", "sdout after reset", 32'(sdout), 32'd0);
    check(dac_ready == 1'b1, "R1", "dac_ready after reset", 32'(dac_ready), 32'd1);
    check(adc_valid == 1'b0, "R1", "adc_valid after reset", 32'(adc_valid), 32'd0);
    check(dac_underrun == 1'b0, "R1", "underrun after reset", 32'(dac_underrun), 32'd0);
    clocks(50);
    check(bclk == 1'b1 && mon_cnt == 0, "R11", "bus stays idle with en low",
          32'(bclk), 32'd1);
  endtask

  // Loopback over n slots at a given frame length and divider
  task automatic t_frames(input int len, input int dv, input int n,
                          input logic [31:0] sd);
    int h = len / 2;
    logic [31:0] exp;
    restart(8'(len), 8'(dv), sd, 1000);
    wait_slots(n, len, dv);
    check(mon_cnt >= n, "R3", "slots decoded", 32'(mon_cnt), 32'(n));
    check(last_per == 2 * (dv + 1), "R2", "bclk period", 32'(last_per), 32'(2 * (dv + 1)));
    for (int i = 0; i < n; i++) begin
      exp = trunc(word_at(i), h);
      check(mon_n[i] == h, "R3", "slot length", 32'(mon_n[i]), 32'(h));
      check(mon_c[i] == i[0], "R4", "slot channel after lrck edge", 32'(mon_c[i]), 32'(i[0]));
      if (h >= 32) check(mon_w[i] == exp, "R5", "serial word", mon_w[i], exp);
      else         check(mon_w[i] == exp, "R6", "short serial word", mon_w[i], exp);
      check(adc_w[i] == exp, (h < 32) ? "R6" : "R7", "captured word", adc_w[i], exp);
      check(adc_c[i] == i[0], "R7", "captured channel", 32'(adc_c[i]), 32'(i[0]));
    end
    check(bclk == 1'b1 && lrck == 1'b0, "R11", "idle after stop",
          {30'd0, bclk, lrck}, 32'd2);
    check(feed_idx >= n, "R8", "words consumed", 32'(feed_idx), 32'(n));
  endtask

  task automatic t_loop_pattern();
    restart(8'd100, 8'd0, 32'h5A5A0000, 1000);
    wait_slots(2, 100, 0);
    check(adc_w[0] == 32'h12345678, "R7", "loopback pattern", adc_w[0], 32'h12345678);
  endtask

  task automatic t_underrun();
    restart(8'd64, 8'd0, 32'hC0FFEE00, 2);
    wait_slots(6, 64, 0);
    check(mon_w[0] == word_at(0), "R8", "first buffered word", mon_w[0], word_at(0));
    check(mon_w[1] == word_at(1), "R8", "second buffered word", mon_w[1], word_at(1));
    for (int i = 2; i < 6; i++)
      check(mon_w[i] == 32'h0, "R9", "zero slot on underrun", mon_w[i], 32'h0);
    check(unr_cnt == mon_cnt + 1 - 2, "R9", "underrun pulses",
          32'(unr_cnt), 32'(mon_cnt + 1 - 2));
  endtask

  task automatic t_len_change();
    int guard = 0;
    restart(8'd100, 8'd0, 32'h13579BDF, 1000);
    en = 1;
    while (mon_cnt < 1 && guard < 20000) begin
      clocks(1);
      guard++;
    end
    cfg_len = 8'd60;  // mid-frame: inside the right slot of frame 0
    wait_slots(6, 100, 0);
    check(mon_n[0] == 50, "R10", "left slot before change", 32'(mon_n[0]), 32'd50);
    check(mon_n[1] == 50, "R10", "right slot keeps old length", 32'(mon_n[1]), 32'd50);
    for (int i = 2; i < 6; i++)
      check(mon_n[i] == 30, "R10", "new slot length", 32'(mon_n[i]), 32'd30);
    check(mon_c[2] == 1'b0, "R10", "new length starts at left slot", 32'(mon_c[2]), 32'd0);
  endtask

  initial begin
    t_reset();
    t_loop_pattern();
    t_frames(100, 0, 8, 32'hA5A50001);
    t_frames(96, 0, 6, 32'h0F0F1234);
    t_frames(50, 0, 6, 32'h87654321);
    t_frames(120, 2, 4, 32'h31415926);
    t_frames(200, 1, 4, 32'h27182818);
    t_frames(254, 0, 4, 32'h16180339);
    t_underrun();
    t_len_change();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule